// File: doc/BRIEF.md
# Serial Flag-Offset Register Port

This block stores the two programmable-flag thresholds of a FIFO, an empty threshold and a full threshold. Both are written and read back through one serial pin pair. Its parallel outputs go straight to the flag comparators elsewhere in the FIFO.

The two thresholds behave as one continuous shift chain. A write stream fills the empty threshold first, least significant bit first, and then continues into the full threshold. A read stream walks the chain in the same order. It always starts again at bit 0 of the empty threshold whenever the read enable is newly raised. The width of each threshold follows from three parameters: a base top-bit index, a double-data-rate flag and a narrow-bus flag.

Top module: `offset_serial_port`

## Requirements
- R1: While `rst` is high at a clock edge, both `empty_ofs` and `full_ofs` take the value of parameter `RST_VAL`, truncated to the threshold width, `rd_bit` is 0, and the read position returns to bit 0 of the empty threshold.
- R2: The threshold width is BASE_TOP+1, plus 1 when `NARROW_BUS`=1 and minus 1 when `DDR_MODE`=1. This gives 16 with defaults (BASE_TOP=15), 17 with `NARROW_BUS`=1, and 15 with `DDR_MODE`=1.
- R3: On each clock edge with `ld_en` high, one bit is taken from `ld_bit`. After 2W consecutive bits, the first bit received sits in `empty_ofs[0]`, bit W-1 of the stream sits in `empty_ofs[W-1]`, bit W sits in `full_ofs[0]`, and the last bit sits in `full_ofs[W-1]`.
- R4: Each load edge moves the whole chain {full, empty} one place toward `empty_ofs[0]` and puts the new bit in `full_ofs[W-1]`. A load that stops partway keeps every bit shifted so far.
- R5: On an edge with `ld_en` low, both `empty_ofs` and `full_ofs` keep their values, whatever `rd_en` is doing.
- R6: On each edge with `rd_en` high and `ld_en` low, `rd_bit` is updated to the next chain bit. The order is `empty_ofs[0]` up to `empty_ofs[W-1]`, then `full_ofs[0]` up to `full_ofs[W-1]`, and then it wraps back to `empty_ofs[0]`.
- R7: The first read edge after `rd_en` rises presents `empty_ofs[0]`, no matter where an earlier read stopped.
- R8: On an edge with both `ld_en` and `rd_en` high, the load takes place, `rd_bit` holds its value and the read position does not advance. When `rd_en` is also low, `rd_bit` holds too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Serial load enable |
| ld_bit | input | 1 | Serial load data |
| rd_en | input | 1 | Serial readback enable |
| rd_bit | output | 1 | Serial readback data, registered |
| empty_ofs | output | W | Empty-flag threshold |
| full_ofs | output | W | Full-flag threshold |

## Verification
The assertions assume that `rd_en` and `ld_en` are low and steady while reset is held. Under that assumption, the first rise of `rd_en` after reset is a genuine new read and the hold checks start from the reset values. They also assume that inputs change only away from the rising edge. The directed stimulus drives every input on the falling edge and keeps both enables low throughout reset. Sessions that interleave loading and reading always keep `rd_en` high across the load, so that the hold-and-resume behaviour is what gets exercised rather than a restart.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  // threshold width from the base top-bit index and the two mode flags
  function automatic int ofs_width(input int base_top, input bit ddr, input bit narrow);
    return base_top + 1 + (narrow ? 1 : 0) - (ddr ? 1 : 0);
  endfunction
endpackage

// File: rtl/ofs_shift_chain.sv
module ofs_shift_chain #(
  parameter int W       = 16,
  parameter int RST_VAL = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_en,
  input  logic           ld_bit,
  output logic [2*W-1:0] chain
);
  localparam logic [W-1:0] INIT = W'(RST_VAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {INIT, INIT};
    end else if (ld_en) begin
      // new bit enters the top of the full threshold, everything moves toward empty bit 0
      chain <= {ld_bit, chain[2*W-1:1]};
    end
  end
endmodule

// File: rtl/ofs_read_seq.sv
module ofs_read_seq #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_en,
  input  logic           ld_en,
  input  logic [2*W-1:0] chain,
  output logic           rd_bit
);
  localparam int            LEN  = 2 * W;
  localparam int            PW   = $clog2(LEN);
  localparam logic [PW-1:0] LAST = PW'(LEN - 1);

  logic [PW-1:0] ptr;
  logic [PW-1:0] start;
  logic          rd_q;
  logic          fresh;

  assign fresh = rd_en && !rd_q;
  assign start = fresh ? '0 : ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
    end else begin
      rd_q <= rd_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      rd_bit <= 1'b0;
    end else if (rd_en && !ld_en) begin
      rd_bit <= chain[start];
      ptr    <= (start == LAST) ? '0 : start + 1'b1;
    end else if (fresh) begin
      ptr <= '0;
    end
  end
endmodule

// File: rtl/offset_serial_port.sv
module offset_serial_port #(
  parameter int BASE_TOP   = 15,
  parameter bit DDR_MODE   = 1'b0,
  parameter bit NARROW_BUS = 1'b0,
  parameter int RST_VAL    = 7,
  localparam int W = ofs_pkg::ofs_width(BASE_TOP, DDR_MODE, NARROW_BUS)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic         ld_bit,
  input  logic         rd_en,
  output logic         rd_bit,
  output logic [W-1:0] empty_ofs,
  output logic [W-1:0] full_ofs
);
  logic [2*W-1:0] chain;

  ofs_shift_chain #(.W(W), .RST_VAL(RST_VAL)) u_chain (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_bit(ld_bit), .chain(chain)
  );

  ofs_read_seq #(.W(W)) u_read (
    .clk(clk), .rst(rst), .rd_en(rd_en), .ld_en(ld_en), .chain(chain), .rd_bit(rd_bit)
  );

  assign empty_ofs = chain[W-1:0];
  assign full_ofs  = chain[2*W-1:W];
endmodule

// File: rtl/offset_serial_port_chk.sv
module offset_serial_port_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         ld_en,
  input logic         ld_bit,
  input logic         rd_en,
  input logic         rd_bit,
  input logic [W-1:0] empty_ofs,
  input logic [W-1:0] full_ofs
);
  AST_LOAD_TOP: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> full_ofs[W-1] == $past(ld_bit)); // R3
  AST_LOAD_CROSS: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> empty_ofs[W-1] == $past(full_ofs[0])); // R4
  AST_LOAD_SLIDE: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> empty_ofs[W-2:0] == $past(empty_ofs[W-1:1])); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $stable(empty_ofs) && $stable(full_ofs)); // R5
  AST_READ_RESTART: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_en) && !ld_en) |=> rd_bit == $past(empty_ofs[0])); // R7
  AST_SO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || ld_en) |=> $stable(rd_bit)); // R8
endmodule

bind offset_serial_port offset_serial_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ld_en(ld_en), .ld_bit(ld_bit), .rd_en(rd_en),
  .rd_bit(rd_bit), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
);

// File: tb/sim_offset_serial_port.sv
module sim_offset_serial_port;
  localparam int W  = 16;
  localparam int W1 = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0, ld_bit = 1'b0, rd_en = 1'b0;
  logic rd_bit;
  logic [W-1:0] empty_ofs, full_ofs;

  logic ld_en1 = 1'b0, ld_bit1 = 1'b0, rd_en1 = 1'b0;
  logic rd_bit1;
  logic [W1-1:0] empty1, full1;
  logic rd_bit2;
  logic [14:0] empty2, full2;

  logic [2*W-1:0]  model;
  logic [2*W1-1:0] model1;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  offset_serial_port u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_bit(ld_bit), .rd_en(rd_en),
    .rd_bit(rd_bit), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );
  offset_serial_port #(.NARROW_BUS(1'b1)) u1 (
    .clk(clk), .rst(rst), .ld_en(ld_en1), .ld_bit(ld_bit1), .rd_en(rd_en1),
    .rd_bit(rd_bit1), .empty_ofs(empty1), .full_ofs(full1)
  );
  offset_serial_port #(.DDR_MODE(1'b1)) u2 (
    .clk(clk), .rst(rst), .ld_en(1'b0), .ld_bit(1'b0), .rd_en(1'b0),
    .rd_bit(rd_bit2), .empty_ofs(empty2), .full_ofs(full2)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic shift_in(input logic b);
    ld_en = 1'b1; ld_bit = b;
    @(posedge clk); @(negedge clk);
    model = {b, model[2*W-1:1]};
  endtask

  task automatic load_word(input logic [2*W-1:0] v, input int n);
    for (int i = 0; i < n; i++) shift_in(v[i]);
    ld_en = 1'b0;
  endtask

  task automatic rd_step(input int idx, input string req);
    @(posedge clk); @(negedge clk);
    check(rd_bit == model[idx], req, 64'(rd_bit), 64'(model[idx]));
  endtask

  task automatic t_reset;
    check(empty_ofs == 16'd7, "R1", 64'(empty_ofs), 64'd7);
    check(full_ofs == 16'd7, "R1", 64'(full_ofs), 64'd7);
    check(rd_bit == 1'b0, "R1", 64'(rd_bit), 64'd0);
    rd_en = 1'b1;
    rd_step(0, "R1");
    rd_en = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_width;
    check($bits(empty_ofs) == 16, "R2", 64'($bits(empty_ofs)), 64'd16);
    check($bits(empty1) == 17, "R2", 64'($bits(empty1)), 64'd17);
    check($bits(full2) == 15, "R2", 64'($bits(full2)), 64'd15);
  endtask

  task automatic t_full_load;
    load_word(32'hA5C3_1E69, 2*W);
    check(empty_ofs == 16'h1E69, "R3", 64'(empty_ofs), 64'h1E69);
    check(full_ofs == 16'hA5C3, "R3", 64'(full_ofs), 64'hA5C3);
  endtask

  task automatic t_partial_load;
    load_word(32'h0000_000B, 4);
    check({full_ofs, empty_ofs} == 32'hBA5C_31E6, "R4", 64'({full_ofs, empty_ofs}), 64'hBA5C31E6);
  endtask

  task automatic t_idle_hold;
    logic [2*W-1:0] snap;
    snap = {full_ofs, empty_ofs};
    rd_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      ld_bit = ~ld_bit;
      @(posedge clk); @(negedge clk);
    end
    rd_en = 1'b0;
    check({full_ofs, empty_ofs} == snap, "R5", 64'({full_ofs, empty_ofs}), 64'(snap));
  endtask

  task automatic t_read_wrap;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b1;
    for (int i = 0; i < 2*W + 3; i++) rd_step(i % (2*W), "R6");
    rd_en = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_restart;
    rd_en = 1'b1;
    for (int i = 0; i < 7; i++) rd_step(i, "R7");
    rd_en = 1'b0;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b1;
    rd_step(0, "R7");
    rd_step(1, "R7");
    rd_en = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_collide;
    logic held;
    rd_en = 1'b1;
    for (int i = 0; i < 3; i++) rd_step(i, "R8");
    held = rd_bit;
    shift_in(~model[0]);
    check(rd_bit == held, "R8", 64'(rd_bit), 64'(held));
    shift_in(model[5]);
    check(rd_bit == held, "R8", 64'(rd_bit), 64'(held));
    ld_en = 1'b0;
    rd_step(3, "R8");
    rd_step(4, "R8");
    rd_en = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_narrow_load;
    logic [2*W1-1:0] v;
    v = 34'h2_F0F1_3C5A;
    for (int i = 0; i < 2*W1; i++) begin
      ld_en1 = 1'b1; ld_bit1 = v[i];
      @(posedge clk); @(negedge clk);
    end
    ld_en1 = 1'b0;
    model1 = v;
    check(empty1 == model1[W1-1:0], "R2", 64'(empty1), 64'(model1[W1-1:0]));
    check(full1 == model1[2*W1-1:W1], "R3", 64'(full1), 64'(model1[2*W1-1:W1]));
  endtask

  initial begin
    model = {16'd7, 16'd7};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_width();
    t_full_load();
    t_partial_load();
    t_idle_hold();
    t_read_wrap();
    t_restart();
    t_collide();
    t_narrow_load();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule